// File: doc/BRIEF.md
# Timer Input Measurement Front End

This block is the input side of a down-counting timer. Besides a plain timer mode that counts an internal tick, it offers three ways of turning an external timer input into counts. Event counting decrements the counter on edges of the input pin, optionally gated by a second pin. Pulse-width measurement counts ticks only while the input sits at a chosen level. Pulse-period measurement counts ticks between two like edges. The input is synchronised by a two-flop chain before any edge or level is taken from it.

Each measurement ends by latching the counter into a capture register and raising a capture flag. A new capture before the flag is cleared sets an overrun bit, and the newer value replaces the held one. Counter underflow raises a separate flag. Both flags drive a single interrupt line. Software loads the counter, selects mode and polarity, and clears the flags through dedicated strobes.

Top module: `mt_measure`

## Requirements
- R1: After reset the counter, capture register, capture flag, overrun bit, underflow flag and interrupt are all zero.
- R2: A one-cycle `load_i` writes `period_i` into the counter on the next edge and takes priority over any counting or capture reload in that cycle.
- R3: In timer mode (`mode_i` = 0) with `start_i` high, the counter drops by one per cycle with `tick_i` high; a step taken at zero reloads `period_i` and sets the underflow flag.
- R4: In event mode (`mode_i` = 2) the counter drops by one per selected edge of the synchronised input (rising when `pol_i` = 0, falling when `pol_i` = 1) and ignores `tick_i`.
- R5: In event mode with `gate_en_i` = 1, input edges arriving while `gate_i` is low leave the counter unchanged; with `gate_i` high they count.
- R6: In width mode (`mode_i` = 3) the counter drops per tick only while the synchronised input is at the active level (high when `pol_i` = 0, low when `pol_i` = 1); when the active level ends the counter is captured and not reloaded, so width = value before the pulse minus captured value, and the next pulse continues from there.
- R7: In period mode (`mode_i` = 4) each selected edge captures the counter and reloads `period_i`; with `tick_i` held high, edges N cycles apart give a captured value C with N = `period_i` - C + 1.
- R8: Every capture sets the capture flag; the capture register keeps its value until the next capture.
- R9: A capture while the capture flag is already set (and not being cleared) sets `overrun_o`; `clr_cap_i` clears both flag and overrun.
- R10: `irq_o` is high exactly while the capture flag or the underflow flag is set; `clr_unf_i` clears the underflow flag.
- R11: With `start_i` low the counter holds its value and no capture happens, except for a load.
- R12: Mode values other than 0, 2, 3 and 4 leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run enable for counting and captures |
| mode_i | input | 3 | Operating mode: 0 timer, 2 event, 3 width, 4 period |
| pol_i | input | 1 | 0: rising edge / high level, 1: falling edge / low level |
| tick_i | input | 1 | Internal count source enable, one step per cycle high |
| meas_i | input | 1 | Asynchronous timer input pin |
| gate_en_i | input | 1 | Enables gating of event edges by `gate_i` |
| gate_i | input | 1 | Event gate pin, high lets edges count |
| load_i | input | 1 | Write `period_i` into the counter |
| period_i | input | CNT_W | Reload and load value |
| clr_cap_i | input | 1 | Clear capture flag and overrun |
| clr_unf_i | input | 1 | Clear underflow flag |
| count_o | output | CNT_W | Current counter value |
| capture_o | output | CNT_W | Last captured counter value |
| cap_flag_o | output | 1 | Measurement complete flag |
| overrun_o | output | 1 | Capture lost before flag cleared |
| unf_flag_o | output | 1 | Counter underflow flag |
| irq_o | output | 1 | Shared interrupt |

## Verification
The bench sweeps pulse widths 1 to 8 and edge spacings 2 to 9 for both polarities, so an off-by-one in the period correction, a reload on the end of a width pulse, or a swapped polarity decode would each show as a wrong captured value. Event counting is run with the tick held high, catching a design that still counts the internal source, and with the gate low, catching one that ignores the gate. Timer mode runs with an irregular tick pattern across several underflows, so a design that reloads one step late or fails to set the flag misses the arithmetic model. Double captures without a clear check overrun, and idle stretches after a capture check that the held value does not follow the running counter.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_TIMER  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_EVENT  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_WIDTH  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_PERIOD = 3'd4;
endpackage

// File: rtl/mt_edge_sync.sv
`timescale 1ns/1ps
module mt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic meas_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= meas_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[LAST-1:0], meas_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];

  assign lvl_o  = sync_q[LAST];
  assign rise_o = sync_q[LAST] & ~prev_q;
  assign fall_o = ~sync_q[LAST] & prev_q;

  // R4
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mt_down_counter.sv
`timescale 1ns/1ps
module mt_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             cap_reload_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             unf_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign unf_o = step_i && !load_i && !cap_reload_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= reload_val_i;
    else if (cap_reload_i)    cnt_q <= reload_val_i;
    else if (step_i) begin
      if (cnt_q == '0)        cnt_q <= reload_val_i;
      else                    cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;

  // R2
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(reload_val_i));

  // R3
  unf_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> cnt_o == $past(reload_val_i));
endmodule

// File: rtl/mt_capture.sv
`timescale 1ns/1ps
module mt_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_evt_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             ovr_o
);
  logic [CNT_W-1:0] cap_q;
  logic             flag_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (cap_evt_i) begin
      cap_q  <= cnt_i;
      flag_q <= 1'b1;
      ovr_q  <= !clr_i && (flag_q || ovr_q);
    end else if (clr_i) begin
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign ovr_o  = ovr_q;

  // R8
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt_i |=> $stable(cap_o));

  // R9
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && flag_o && !clr_i) |=> ovr_o);
endmodule

// File: rtl/mt_measure.sv
`timescale 1ns/1ps
module mt_measure
  import mt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pol_i,
  input  logic              tick_i,
  input  logic              meas_i,
  input  logic              gate_en_i,
  input  logic              gate_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              clr_cap_i,
  input  logic              clr_unf_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  capture_o,
  output logic              cap_flag_o,
  output logic              overrun_o,
  output logic              unf_flag_o,
  output logic              irq_o
);
  logic lvl, rise, fall;
  logic sel_edge, end_edge, active, gate_ok;
  logic step, cap_evt, cap_reload, unf_pulse;
  logic unf_q;

  mt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .meas_i (meas_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sel_edge = pol_i ? fall : rise;
  assign end_edge = pol_i ? rise : fall;
  assign active   = lvl ^ pol_i;
  assign gate_ok  = !gate_en_i || gate_i;

  always_comb begin
    step       = 1'b0;
    cap_evt    = 1'b0;
    cap_reload = 1'b0;
    if (start_i) begin
      unique case (mode_i)
        MODE_TIMER:  step = tick_i;
        MODE_EVENT:  step = sel_edge && gate_ok;
        MODE_WIDTH: begin
          step    = tick_i && active;
          cap_evt = end_edge;
        end
        MODE_PERIOD: begin
          step       = tick_i;
          cap_evt    = sel_edge;
          cap_reload = sel_edge;
        end
        default: ;
      endcase
    end
  end

  mt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .cap_reload_i (cap_reload),
    .step_i       (step),
    .reload_val_i (period_i),
    .cnt_o        (count_o),
    .unf_o        (unf_pulse)
  );

  mt_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_evt_i (cap_evt),
    .clr_i     (clr_cap_i),
    .cnt_i     (count_o),
    .cap_o     (capture_o),
    .flag_o    (cap_flag_o),
    .ovr_o     (overrun_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        unf_q <= 1'b0;
    else if (unf_pulse) unf_q <= 1'b1;
    else if (clr_unf_i) unf_q <= 1'b0;

  assign unf_flag_o = unf_q;
  assign irq_o      = cap_flag_o | unf_q;

  // R10
  unf_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_pulse |=> irq_o);

  // R11
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !load_i) |=> $stable(count_o));

  // R4
  event_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == MODE_EVENT && !sel_edge && !load_i) |=> $stable(count_o));

  // R6
  width_noreload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == MODE_WIDTH && cap_evt && !load_i) |=> $stable(count_o));
endmodule

// File: tb/mt_measure_tb.sv
`timescale 1ns/1ps
module mt_measure_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, start_i, pol_i, tick_i, meas_i, gate_en_i, gate_i;
  logic load_i, clr_cap_i, clr_unf_i;
  logic [2:0] mode_i;
  logic [W-1:0] period_i, count_o, capture_o;
  logic cap_flag_o, overrun_o, unf_flag_o, irq_o;

  mt_measure #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .pol_i(pol_i), .tick_i(tick_i), .meas_i(meas_i), .gate_en_i(gate_en_i),
    .gate_i(gate_i), .load_i(load_i), .period_i(period_i),
    .clr_cap_i(clr_cap_i), .clr_unf_i(clr_unf_i), .count_o(count_o),
    .capture_o(capture_o), .cap_flag_o(cap_flag_o), .overrun_o(overrun_o),
    .unf_flag_o(unf_flag_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [W-1:0] v);
    period_i = v; load_i = 1'b1; cyc(1); load_i = 1'b0;
  endtask

  task automatic clr_cap();
    clr_cap_i = 1'b1; cyc(1); clr_cap_i = 1'b0;
  endtask

  task automatic clr_unf();
    clr_unf_i = 1'b1; cyc(1); clr_unf_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, held;
    logic uexp;
    int ex;
    rst_ni = 0; start_i = 0; pol_i = 0; tick_i = 0; meas_i = 0;
    gate_en_i = 0; gate_i = 0; load_i = 0; clr_cap_i = 0; clr_unf_i = 0;
    mode_i = 3'd0; period_i = '0;
    cyc(3);
    rst_ni = 1;
    cyc(1);
    chk("R1 count", count_o, 0);
    chk("R1 capture", capture_o, 0);
    chk("R1 flags", {cap_flag_o, overrun_o, unf_flag_o, irq_o}, 0);

    // R3: timer mode with irregular tick
    for (int p = 1; p <= 5; p++) begin
      start_i = 0; mode_i = 3'd0;
      do_load(W'(p));
      clr_unf();
      v = W'(p); uexp = 0; start_i = 1;
      for (int k = 0; k < 2 * p + 4; k++) begin
        tick_i = (k % 3 != 2);
        cyc(1);
        if (tick_i) begin
          if (v == 0) begin v = W'(p); uexp = 1; end
          else v = v - 1;
        end
        chk("R3 count", count_o, v);
        chk("R3 underflow flag", unf_flag_o, uexp);
      end
      start_i = 0; tick_i = 0;
      chk("R10 irq on underflow", irq_o, 1);
      clr_unf();
      chk("R10 irq after clear", irq_o, 0);
    end

    // R2: load priority while counting
    start_i = 1; tick_i = 1; mode_i = 3'd0;
    cyc(2);
    do_load(16'd77);
    chk("R2 load", count_o, 77);
    cyc(1);
    chk("R2 count after load", count_o, 76);

    // R11: stopped
    start_i = 0;
    held = count_o;
    cyc(6);
    chk("R11 hold", count_o, held);

    // R12: unused modes
    start_i = 1;
    mode_i = 3'd1; cyc(4); chk("R12 mode 1 hold", count_o, held);
    mode_i = 3'd5; cyc(4); chk("R12 mode 5 hold", count_o, held);
    mode_i = 3'd7; cyc(4); chk("R12 mode 7 hold", count_o, held);
    start_i = 0; clr_unf();

    // R4 / R5: event counting
    for (int p = 0; p < 2; p++) begin
      start_i = 0; mode_i = 3'd2; pol_i = p[0]; meas_i = p[0];
      gate_en_i = 0; gate_i = 0;
      cyc(5);
      do_load(16'd200);
      start_i = 1; tick_i = 1; ex = 200;
      for (int m = 1; m <= 6; m++) begin
        meas_i = ~p[0]; cyc(2); meas_i = p[0]; cyc(3);
        ex--;
        chk("R4 event count", count_o, ex[W-1:0]);
      end
      gate_en_i = 1; gate_i = 0;
      for (int m = 0; m < 3; m++) begin
        meas_i = ~p[0]; cyc(2); meas_i = p[0]; cyc(3);
      end
      chk("R5 gated off", count_o, ex[W-1:0]);
      gate_i = 1;
      for (int m = 0; m < 2; m++) begin
        meas_i = ~p[0]; cyc(2); meas_i = p[0]; cyc(3);
      end
      ex -= 2;
      chk("R5 gated on", count_o, ex[W-1:0]);
      chk("R4 no capture", cap_flag_o, 0);
      gate_en_i = 0; start_i = 0;
    end

    // R6: width measurement
    for (int p = 0; p < 2; p++) begin
      start_i = 0; mode_i = 3'd3; pol_i = p[0]; meas_i = p[0];
      cyc(5);
      clr_cap();
      do_load(16'd300);
      start_i = 1; tick_i = 1; ex = 300;
      for (int k = 1; k <= 8; k++) begin
        meas_i = ~p[0]; cyc(k); meas_i = p[0]; cyc(5);
        ex -= k;
        chk("R6 captured width", capture_o, ex[W-1:0]);
        chk("R6 no reload", count_o, ex[W-1:0]);
        chk("R8 flag set", cap_flag_o, 1);
        chk("R10 irq on capture", irq_o, 1);
        clr_cap();
        chk("R9 flag cleared", cap_flag_o, 0);
      end
      start_i = 0;
    end

    // R7 / R8 / R9: period measurement
    for (int p = 0; p < 2; p++) begin
      start_i = 0; mode_i = 3'd4; pol_i = p[0]; meas_i = p[0];
      cyc(5);
      do_load(16'd500);
      clr_cap();
      start_i = 1; tick_i = 1;
      for (int n = 2; n <= 9; n++) begin
        meas_i = ~p[0]; cyc(1); meas_i = p[0]; cyc(n - 1);
        meas_i = ~p[0]; cyc(1); meas_i = p[0]; cyc(5);
        chk("R7 captured period", capture_o, 32'(500 - n + 1));
        chk("R9 overrun", overrun_o, 1);
        clr_cap();
        chk("R9 overrun cleared", {cap_flag_o, overrun_o}, 0);
        held = capture_o;
        cyc(10);
        chk("R8 capture held", capture_o, held);
      end
      start_i = 0;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule